// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 24 general-purpose input pins and raises an interrupt when any of them changes level. The pins are split into three groups of eight. Each pin has its own mask bit, and each group has one pending flag, one enable bit and one interrupt request line. A rising or a falling edge on any unmasked pin sets the flag of the pin's group. The flag does not record which pin moved. The interrupt handler has to work that out by reading the pins itself.

The pins are first brought into the clock domain by a two-stage synchronizer. Each pin is then compared with its value from the previous cycle. A request line goes high only while all three of these are 1: the group's flag, the group's enable bit and the global interrupt enable input. A flag is cleared in one of two ways. Software can write 1 to it over a small register bus. The interrupt logic can also pulse the per-group acknowledge input. Group 1 covers pins 14..8 only. Pin 15 is not part of it and can never raise an interrupt.

Top module: `grp_toggle_irq`

## Requirements
- R1: After reset, every mask register, the group enable register and the pending flags are 0, and `irq` is 0.
- R2: Register map at `reg_addr`: addresses 0, 1 and 2 hold the masks of groups 0, 1 and 2; bit k of the mask for group g belongs to pin 8g+k. Address 3 holds the group enables in bits 2:0. Address 4 holds the pending flags in bits 2:0. A write at addresses 0 to 3 stores `reg_wdata`. Bits that do not exist read 0, and any other address reads 0.
- R3: A change in either direction on a pin whose mask bit is 1 sets its group's flag. The flag reads 1 after the third rising edge that follows the pin change, and not before.
- R4: A pin whose mask bit is 0 never sets a flag. Unmasking the pin after it has toggled does not set the flag either.
- R5: Pin 15 is not part of any group. Bit 7 of the group 1 mask always reads 0, and toggling pin 15 never sets a flag.
- R6: `irq[g]` is 1 exactly when flag g, enable bit g and `gie` are all 1. While `gie` is 0, every `irq` bit is 0.
- R7: Writing to address 4 clears each flag whose data bit is 1 and leaves flags written with 0 unchanged.
- R8: A one-cycle pulse on `ack[g]` clears flag g only.
- R9: If a change is detected in the same cycle that a flag is cleared by a write or by `ack`, the flag stays set.
- R10: Pin levels that are present when reset is released are taken as the starting values and do not count as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | 24 | Asynchronous input pins; group g is pins 8g+7..8g |
| gie | input | 1 | Global interrupt enable |
| ack | input | 3 | Per-group flag clear pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq | output | 3 | Per-group interrupt requests |

## Verification
Detecting a pin change and clearing a flag can both happen in the same cycle. The clear can come from a write or from the acknowledge input. The bench first sets a group's flag with one pin. It then toggles a second unmasked pin in that group and lines up a write-1-clear so that it lands on the exact edge where the change is registered. This is two negative edges after the pin is driven. The flag must read 1 afterwards, and a later clear that has no coinciding change must empty it. The same is done with `ack`.

// File: rtl/grp_toggle_irq.sv
module grp_toggle_irq #(
  parameter int GROUPS = 3,
  parameter int WIDTH  = 8,
  parameter int AW     = 3,
  parameter logic [GROUPS*WIDTH-1:0] PIN_PRESENT = 24'hFF7FFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS*WIDTH-1:0]   pins,
  input  logic                      gie,
  input  logic [GROUPS-1:0]         ack,
  input  logic                      reg_wr,
  input  logic [AW-1:0]             reg_addr,
  input  logic [WIDTH-1:0]          reg_wdata,
  output logic [WIDTH-1:0]          reg_rdata,
  output logic [GROUPS-1:0]         irq
);
  localparam int NP = GROUPS * WIDTH;
  localparam logic [AW-1:0] EN_A   = AW'(GROUPS);
  localparam logic [AW-1:0] FLAG_A = AW'(GROUPS + 1);

  logic [NP-1:0] s1, s2, prev;
  logic [1:0] warm;
  logic [GROUPS-1:0][WIDTH-1:0] mask;
  logic [GROUPS-1:0] en, flag, grp_hit, clr;

  wire armed = (warm == 2'd3);
  wire [NP-1:0] diff = (s2 ^ prev) & mask & PIN_PRESENT & {NP{armed}};

  always_comb begin
    for (int g = 0; g < GROUPS; g++) grp_hit[g] = |diff[g*WIDTH +: WIDTH];
  end

  assign clr = (reg_wr && reg_addr == FLAG_A) ? reg_wdata[GROUPS-1:0] : '0;
  assign irq = flag & en & {GROUPS{gie}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0; warm <= '0;
    end else begin
      s1 <= pins;
      s2 <= s1;
      prev <= s2;
      if (!armed) warm <= warm + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0; en <= '0; flag <= '0;
    end else begin
      for (int g = 0; g < GROUPS; g++)
        if (reg_wr && reg_addr == AW'(g))
          mask[g] <= reg_wdata & PIN_PRESENT[g*WIDTH +: WIDTH];
      if (reg_wr && reg_addr == EN_A) en <= reg_wdata[GROUPS-1:0];
      flag <= (flag & ~clr & ~ack) | grp_hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < GROUPS; g++)
      if (reg_addr == AW'(g)) reg_rdata = mask[g];
    if (reg_addr == EN_A)   reg_rdata = {{(WIDTH-GROUPS){1'b0}}, en};
    if (reg_addr == FLAG_A) reg_rdata = {{(WIDTH-GROUPS){1'b0}}, flag};
  end

  a_r3_set_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((flag & ~$past(flag) & ~$past(grp_hit)) == '0));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hit != '0) |=> ((flag & $past(grp_hit)) == $past(grp_hit)));
  a_r7_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~grp_hit) != '0) |=> ((flag & $past(clr & ~grp_hit)) == '0));
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~grp_hit) != '0) |=> ((flag & $past(ack & ~grp_hit)) == '0));
  a_r6_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == '0));
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flag) == '0));
endmodule

// File: tb/sim_grp_toggle_irq.sv
`timescale 1ns/100ps
module sim_grp_toggle_irq;
  logic clk = 0, rst_n = 0, gie = 0, reg_wr = 0;
  logic [23:0] pins = 24'hFFFFFF;
  logic [2:0] ack = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [2:0] irq;
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  grp_toggle_irq u0 (.clk(clk), .rst_n(rst_n), .pins(pins), .gie(gie), .ack(ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      nfail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected <= 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_flags(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    rd(3'd4, d); chk(tag, d, exp);
  endtask

  task automatic t_reset_and_baseline();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irq", {5'b0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 8'hFF;
    @(negedge clk); reg_wr = 0;
    settle(); settle();
    chk_flags("R10 levels at reset release not a change", 8'h00);
    wr(3'd0, 8'h00);
    pins = 24'h000000;
    settle();
    wr(3'd4, 8'h07);
    chk_flags("R10 cleanup", 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(3'd0, 8'hA5); rd(3'd0, d); chk("R2 mask0 readback", d, 8'hA5);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R5 mask1 bit7 reads 0", d, 8'h7F);
    wr(3'd2, 8'h3C); rd(3'd2, d); chk("R2 mask2 readback", d, 8'h3C);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R2 enable upper bits read 0", d, 8'h07);
    rd(3'd5, d); chk("R2 unused address reads 0", d, 8'h00);
    for (int a = 0; a < 4; a++) wr(3'(a), 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wr(3'd2, 8'h02);
    @(negedge clk); pins[17] = 1;
    @(posedge clk); @(posedge clk); #1; rd(3'd4, d);
    chk("R3 no flag before third edge", d, 8'h00);
    @(posedge clk); #1; rd(3'd4, d);
    chk("R3 rising edge sets group2 flag", d, 8'h04);
    wr(3'd4, 8'h04);
    chk_flags("R7 write 1 clears", 8'h00);
    @(negedge clk); pins[17] = 0; settle();
    chk_flags("R3 falling edge sets group2 flag", 8'h04);
    wr(3'd4, 8'h03);
    chk_flags("R7 write 0 leaves flag", 8'h04);
    wr(3'd4, 8'h04);
    wr(3'd0, 8'h01);
    @(negedge clk); pins[0] = 1; settle();
    chk_flags("R3 group0 pin0 edge", 8'h01);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd0, 8'hF7);
    @(negedge clk); pins[3] = 1; settle();
    chk_flags("R4 masked pin toggle ignored", 8'h00);
    wr(3'd0, 8'hFF); settle();
    chk_flags("R4 unmask after toggle no flag", 8'h00);
    @(negedge clk); pins[3] = 0; settle();
    chk_flags("R4 unmasked pin now sets", 8'h01);
    wr(3'd4, 8'h01); wr(3'd0, 8'h00);
  endtask

  task automatic t_hole();
    wr(3'd1, 8'hFF);
    @(negedge clk); pins[15] = 1; settle();
    chk_flags("R5 pin15 never sets flag", 8'h00);
    @(negedge clk); pins[8] = 1; settle();
    chk_flags("R5 pin8 sets group1", 8'h02);
    wr(3'd4, 8'h02); wr(3'd1, 8'h00);
  endtask

  task automatic t_irq();
    wr(3'd0, 8'h01);
    @(negedge clk); pins[0] = 0; settle();
    gie = 1; wr(3'd3, 8'h00); #1;
    chk("R6 enable off no irq", {5'b0, irq}, 8'h00);
    wr(3'd3, 8'h07); gie = 0; #1;
    chk("R6 gie off no irq", {5'b0, irq}, 8'h00);
    gie = 1; #1;
    chk("R6 irq group0", {5'b0, irq}, 8'h01);
    @(negedge clk); ack = 3'b010; @(negedge clk); ack = 0;
    chk_flags("R8 ack other group leaves flag", 8'h01);
    @(negedge clk); ack = 3'b001; @(negedge clk); ack = 0; #1;
    chk_flags("R8 ack clears flag", 8'h00);
    chk("R8 irq drops after ack", {5'b0, irq}, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_collide();
    wr(3'd0, 8'h03);
    @(negedge clk); pins[0] = 1; settle();
    chk_flags("R9 setup flag", 8'h01);
    @(negedge clk); pins[1] = 1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd4; reg_wdata = 8'h01;
    @(negedge clk); reg_wr = 0;
    chk_flags("R9 change beats write clear", 8'h01);
    wr(3'd4, 8'h01);
    chk_flags("R7 later clear empties", 8'h00);
    @(negedge clk); pins[1] = 0;
    @(negedge clk);
    @(negedge clk); ack = 3'b001;
    @(negedge clk); ack = 0;
    chk_flags("R9 change beats ack", 8'h01);
    wr(3'd4, 8'h01); wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_baseline();
    t_regs();
    t_edges();
    t_mask();
    t_hole();
    t_irq();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule